// File: doc/BRIEF.md
# Per-Layer Road Hit Selector

This block picks silicon hits for one track road at a time. Each road opens with a start pulse. The start pulse carries two anchor words, taken from the innermost and outermost fiber-tracker layers, and these anchors define the road. Candidate clusters then stream in, one per cycle. Each candidate carries a layer code and a signed offset measured from the road centre.

Across the four silicon layers the block keeps one candidate per layer, the one with the smallest absolute offset. A candidate whose absolute offset is above the half-width parameter never takes part. The default half-width of 1000 offset units stands for a road about 2 mm wide.

An end marker closes the road. In the next cycle the block presents the following:
- a layer-hit mask;
- the kept offsets;
- the two anchors, unchanged;
- an accept decision, which passes roads with three or four populated layers.

A new road may start in the cycle directly after an end, or in the same cycle as an end, so no idle cycle is needed between roads.

Top module: `road_hit_selector`

## Requirements
- R1: While reset is asserted, and until the first road closes after it, res_valid_o, res_mask_o, res_off_o, res_accept_o and both anchor outputs are all zero.
- R2: res_valid_o is high for exactly one cycle, the cycle after a cycle in which end_i is high, and is low in every other cycle.
- R3: For each layer, the reported offset is that of the in-window candidate of that layer whose absolute offset is smallest within the road.
- R4: When two in-window candidates of a layer have equal absolute offset, the one that arrived earlier is kept.
- R5: A candidate whose absolute offset is greater than HALF_W (default 1000) is ignored. A candidate whose absolute offset equals HALF_W is eligible.
- R6: Bit i of res_mask_o is set exactly when at least one eligible candidate with clu_layer_i equal to i arrived in the road.
- R7: Layer i's offset sits at res_off_o bits [12*i+11 : 12*i]. It is zero when that layer has no hit.
- R8: res_accept_o is 1 when three or four mask bits are set, and 0 when two or fewer are set.
- R9: The anchor outputs return the anchor inputs that were present with the road's start pulse, unchanged.
- R10: start_i discards all state from the previous road, including when it arrives in the cycle right after an end or in the same cycle as an end. A candidate or end marker in the start cycle belongs to the new road.
- R11: Between reported roads, the result outputs other than res_valid_o keep the values of the last reported road.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Opens a new road and clears the held state |
| anchor_in_i | input | 16 | Inner fiber anchor, taken with start_i |
| anchor_out_i | input | 16 | Outer fiber anchor, taken with start_i |
| clu_valid_i | input | 1 | A candidate cluster is present |
| clu_layer_i | input | 2 | Silicon layer code of the candidate, 0 to 3 |
| clu_off_i | input | 12 | Signed two's-complement offset from the road centre |
| end_i | input | 1 | Closes the road; a candidate in the same cycle is included |
| res_valid_o | output | 1 | One-cycle pulse marking a road result |
| res_mask_o | output | 4 | Bit i set when layer i has a hit |
| res_off_o | output | 48 | Kept offsets, layer i at bits [12i+11:12i] |
| res_accept_o | output | 1 | Road has at least three populated layers |
| res_anchor_in_o | output | 16 | Inner anchor of the reported road |
| res_anchor_out_o | output | 16 | Outer anchor of the reported road |

## Verification
Directed roads present, within single layers, candidates that approach the centre, that move away from it, and that mirror each other in sign. These patterns separate a comparison on magnitude from one on signed value, and strict tie handling from non-strict. Offsets exactly at the half-width, one unit beyond it, and at the extreme negative code test the window edge and the absolute-value arithmetic. Roads with two, three and four populated layers bracket the vote. Roads placed back to back, sharing a start/end cycle, or closing with no candidate in the end cycle show whether the state clears at the right beat. Many random roads with idle gaps are compared against a behavioural model on every cycle.

// File: rtl/road_sel_pkg.sv
package road_sel_pkg;

  // Magnitude of a sign-extended offset.
  function automatic logic [31:0] off_mag(input logic signed [31:0] v);
    return (v < 0) ? 32'(-v) : 32'(v);
  endfunction

  // True when a candidate of magnitude a is strictly closer than magnitude b.
  function automatic logic strictly_closer(input logic [31:0] a, input logic [31:0] b);
    return a < b;
  endfunction

  // True when a magnitude lies inside the road half-width.
  function automatic logic in_window(input logic [31:0] m, input logic [31:0] half_w);
    return m <= half_w;
  endfunction

endpackage

// File: rtl/road_layer_slot.sv
module road_layer_slot
  import road_sel_pkg::*;
#(
  parameter int OFF_W  = 12,
  parameter int HALF_W = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             hit_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             have_o,
  output logic [OFF_W-1:0] off_o,
  output logic             taken_o
);

  function automatic logic signed [31:0] sext(input logic [OFF_W-1:0] v);
    return signed'({{(32-OFF_W){v[OFF_W-1]}}, v});
  endfunction

  logic             have_q;
  logic [OFF_W-1:0] off_q;
  logic             have_base;
  logic [OFF_W-1:0] off_base;
  logic [31:0]      mag_new;
  logic [31:0]      mag_old;

  always_comb begin
    have_base = clear_i ? 1'b0 : have_q;
    off_base  = clear_i ? '0 : off_q;
    mag_new   = off_mag(sext(off_i));
    mag_old   = off_mag(sext(off_base));
    taken_o   = hit_i && in_window(mag_new, 32'(HALF_W)) &&
                (!have_base || strictly_closer(mag_new, mag_old));
    have_o    = have_base | taken_o;
    off_o     = taken_o ? off_i : off_base;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      off_q  <= '0;
    end else begin
      have_q <= have_o;
      off_q  <= off_o;
    end
  end

endmodule

// File: rtl/road_vote.sv
module road_vote #(
  parameter int LAYERS     = 4,
  parameter int MIN_LAYERS = 3
) (
  input  logic [LAYERS-1:0] mask_i,
  output logic              accept_o
);

  localparam int CNT_W = $clog2(LAYERS + 1);

  logic [CNT_W-1:0] populated;

  always_comb begin
    populated = '0;
    for (int i = 0; i < LAYERS; i++) begin
      populated = populated + CNT_W'(mask_i[i]);
    end
    accept_o = (32'(populated) >= 32'(MIN_LAYERS));
  end

endmodule

// File: rtl/road_hit_selector.sv
module road_hit_selector #(
  parameter int LAYERS     = 4,
  parameter int OFF_W      = 12,
  parameter int ANCHOR_W   = 16,
  parameter int HALF_W     = 1000,
  parameter int MIN_LAYERS = 3,
  localparam int LAY_W     = (LAYERS > 1) ? $clog2(LAYERS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [ANCHOR_W-1:0]      anchor_in_i,
  input  logic [ANCHOR_W-1:0]      anchor_out_i,
  input  logic                     clu_valid_i,
  input  logic [LAY_W-1:0]         clu_layer_i,
  input  logic [OFF_W-1:0]         clu_off_i,
  input  logic                     end_i,
  output logic                     res_valid_o,
  output logic [LAYERS-1:0]        res_mask_o,
  output logic [LAYERS*OFF_W-1:0]  res_off_o,
  output logic                     res_accept_o,
  output logic [ANCHOR_W-1:0]      res_anchor_in_o,
  output logic [ANCHOR_W-1:0]      res_anchor_out_o
);

  logic [LAYERS-1:0]       have_next;
  logic [LAYERS*OFF_W-1:0] off_next;
  logic [LAYERS-1:0]       layer_taken;
  logic                    vote_pass;
  logic                    road_close;
  logic [ANCHOR_W-1:0]     anc_in_q;
  logic [ANCHOR_W-1:0]     anc_out_q;
  logic [ANCHOR_W-1:0]     anc_in_eff;
  logic [ANCHOR_W-1:0]     anc_out_eff;

  assign road_close = end_i;

  for (genvar g = 0; g < LAYERS; g++) begin : g_slot
    logic hit;
    assign hit = clu_valid_i && (clu_layer_i == LAY_W'(g));
    road_layer_slot #(
      .OFF_W  (OFF_W),
      .HALF_W (HALF_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_i),
      .hit_i   (hit),
      .off_i   (clu_off_i),
      .have_o  (have_next[g]),
      .off_o   (off_next[g*OFF_W +: OFF_W]),
      .taken_o (layer_taken[g])
    );
  end

  road_vote #(
    .LAYERS     (LAYERS),
    .MIN_LAYERS (MIN_LAYERS)
  ) u_vote (
    .mask_i   (have_next),
    .accept_o (vote_pass)
  );

  assign anc_in_eff  = start_i ? anchor_in_i  : anc_in_q;
  assign anc_out_eff = start_i ? anchor_out_i : anc_out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      anc_in_q  <= '0;
      anc_out_q <= '0;
    end else begin
      anc_in_q  <= anc_in_eff;
      anc_out_q <= anc_out_eff;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_o      <= 1'b0;
      res_mask_o       <= '0;
      res_off_o        <= '0;
      res_accept_o     <= 1'b0;
      res_anchor_in_o  <= '0;
      res_anchor_out_o <= '0;
    end else begin
      res_valid_o <= road_close;
      if (road_close) begin
        res_mask_o       <= have_next;
        res_off_o        <= off_next;
        res_accept_o     <= vote_pass;
        res_anchor_in_o  <= anc_in_eff;
        res_anchor_out_o <= anc_out_eff;
      end
    end
  end

endmodule

// File: rtl/road_hit_selector_chk.sv
module road_hit_selector_chk
  import road_sel_pkg::*;
#(
  parameter int LAYERS     = 4,
  parameter int OFF_W      = 12,
  parameter int ANCHOR_W   = 16,
  parameter int HALF_W     = 1000,
  parameter int MIN_LAYERS = 3,
  parameter int LAY_W      = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_i,
  input logic [ANCHOR_W-1:0]     anchor_in_i,
  input logic [ANCHOR_W-1:0]     anchor_out_i,
  input logic                    clu_valid_i,
  input logic [LAY_W-1:0]        clu_layer_i,
  input logic [OFF_W-1:0]        clu_off_i,
  input logic                    end_i,
  input logic                    res_valid_o,
  input logic [LAYERS-1:0]       res_mask_o,
  input logic [LAYERS*OFF_W-1:0] res_off_o,
  input logic                    res_accept_o,
  input logic [ANCHOR_W-1:0]     res_anchor_in_o,
  input logic [ANCHOR_W-1:0]     res_anchor_out_o
);

  AST_VALID_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rst_n)
    end_i |=> res_valid_o); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !end_i |=> !res_valid_o); // R2

  AST_ACCEPT_VOTE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (res_accept_o == ($countones(res_mask_o) >= MIN_LAYERS))); // R8

  AST_SINGLE_BEAT_ANCHOR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && end_i) |=> (res_anchor_in_o == $past(anchor_in_i) &&
                            res_anchor_out_o == $past(anchor_out_i))); // R9

  AST_HOLD_BETWEEN_ROADS: assert property (@(posedge clk) disable iff (!rst_n)
    !end_i |=> ($stable(res_mask_o) && $stable(res_off_o) && $stable(res_accept_o))); // R11

  for (genvar g = 0; g < LAYERS; g++) begin : g_lay
    logic [OFF_W-1:0] lane;
    assign lane = res_off_o[g*OFF_W +: OFF_W];

    AST_MISSING_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !res_mask_o[g]) |-> (lane == '0)); // R7

    AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && res_mask_o[g]) |->
        (off_mag(signed'({{(32-OFF_W){lane[OFF_W-1]}}, lane})) <= 32'(HALF_W))); // R5
  end

endmodule

bind road_hit_selector road_hit_selector_chk #(
  .LAYERS     (LAYERS),
  .OFF_W      (OFF_W),
  .ANCHOR_W   (ANCHOR_W),
  .HALF_W     (HALF_W),
  .MIN_LAYERS (MIN_LAYERS),
  .LAY_W      (LAY_W)
) u_chk (.*);

// File: tb/tb_road_hit_selector.sv
module tb_road_hit_selector;

  localparam int HALF = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] anchor_in_i = '0;
  logic [15:0] anchor_out_i = '0;
  logic        clu_valid_i = 1'b0;
  logic [1:0]  clu_layer_i = '0;
  logic [11:0] clu_off_i = '0;
  logic        end_i = 1'b0;
  logic        res_valid_o;
  logic [3:0]  res_mask_o;
  logic [47:0] res_off_o;
  logic        res_accept_o;
  logic [15:0] res_anchor_in_o;
  logic [15:0] res_anchor_out_o;

  road_hit_selector dut (.*);

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // behavioural model state
  int m_have[4];
  int m_off[4];
  int m_ain = 0, m_aout = 0;
  bit          e_valid = 0;
  logic [3:0]  e_mask = '0;
  logic [47:0] e_off = '0;
  bit          e_acc = 0;
  logic [15:0] e_ain = '0, e_aout = '0;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic compare(input string tag);
    compared++;
    if (res_valid_o !== e_valid) begin
      mismatched++;
      $display("FAIL %s valid actual=%0b expected=%0b", tag, res_valid_o, e_valid);
    end
    if (res_mask_o !== e_mask) begin
      mismatched++;
      $display("FAIL %s mask actual=%b expected=%b", tag, res_mask_o, e_mask);
    end
    if (res_off_o !== e_off) begin
      mismatched++;
      $display("FAIL %s offsets actual=%h expected=%h", tag, res_off_o, e_off);
    end
    if (res_accept_o !== e_acc) begin
      mismatched++;
      $display("FAIL %s accept actual=%0b expected=%0b", tag, res_accept_o, e_acc);
    end
    if (res_anchor_in_o !== e_ain || res_anchor_out_o !== e_aout) begin
      mismatched++;
      $display("FAIL %s anchors actual=%h/%h expected=%h/%h", tag,
               res_anchor_in_o, res_anchor_out_o, e_ain, e_aout);
    end
  endtask

  // One cycle: drive at negedge, update model, check at following negedge.
  task automatic step(input bit s, input bit e, input bit v, input int lay, input int off,
                      input int ain, input int aout, input string tag);
    int cnt;
    start_i      = s;
    end_i        = e;
    clu_valid_i  = v;
    clu_layer_i  = 2'(lay);
    clu_off_i    = 12'(off);
    anchor_in_i  = 16'(ain);
    anchor_out_i = 16'(aout);
    if (s) begin
      for (int i = 0; i < 4; i++) begin m_have[i] = 0; m_off[i] = 0; end
      m_ain = ain; m_aout = aout;
    end
    if (v && iabs(off) <= HALF && (m_have[lay] == 0 || iabs(off) < iabs(m_off[lay]))) begin
      m_have[lay] = 1;
      m_off[lay]  = off;
    end
    e_valid = e;
    if (e) begin
      cnt = 0;
      for (int i = 0; i < 4; i++) begin
        e_mask[i] = (m_have[i] != 0);
        e_off[i*12 +: 12] = 12'(m_off[i]);
        cnt += m_have[i];
      end
      e_acc  = (cnt >= 3);
      e_ain  = 16'(m_ain);
      e_aout = 16'(m_aout);
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_have[i] = 0; m_off[i] = 0; end
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    idle("R1 after reset");

    // R3 nearest per layer, sign-independent magnitude
    step(1, 0, 1, 0, 300, 16'h1111, 16'h2222, "R3");
    step(0, 0, 1, 0, -100, 0, 0, "R3");
    step(0, 0, 1, 0, 200, 0, 0, "R3");
    step(0, 0, 1, 1, -50, 0, 0, "R3");
    step(0, 0, 1, 1, 40, 0, 0, "R3");
    step(0, 0, 1, 2, 5, 0, 0, "R3");
    step(0, 1, 1, 3, -7, 0, 0, "R3 R6 R8 R9 four layers");
    idle("R2 pulse ends");
    idle("R11 hold");

    // R4 ties keep earlier; two layers reject
    step(1, 0, 1, 0, 25, 16'h0abc, 16'h0def, "R4");
    step(0, 0, 1, 0, -25, 0, 0, "R4");
    step(0, 0, 1, 1, -60, 0, 0, "R4");
    step(0, 0, 1, 1, 60, 0, 0, "R4");
    step(0, 1, 0, 0, 0, 0, 0, "R4 R8 two layers reject, end without cluster");

    // R5 window edges and extreme codes
    step(1, 0, 1, 2, 1001, 5, 6, "R5");
    step(0, 0, 1, 2, -1000, 0, 0, "R5");
    step(0, 0, 1, 2, -2048, 0, 0, "R5");
    step(0, 0, 1, 3, 2047, 0, 0, "R5");
    step(0, 0, 1, 0, -1001, 0, 0, "R5");
    step(0, 1, 1, 1, 1000, 0, 0, "R5 R6 edge accepted, beyond ignored");

    // R8 three layers, R7 missing lane zero; back-to-back R10
    step(1, 0, 1, 0, 12, 7, 8, "R8");
    step(0, 0, 1, 1, -3, 0, 0, "R8");
    step(0, 1, 1, 3, 9, 0, 0, "R7 R8 three layers accept");
    step(1, 0, 1, 2, 33, 9, 10, "R10 start right after end");
    step(0, 1, 0, 0, 0, 0, 0, "R10 one layer after clear");
    step(1, 1, 1, 1, -44, 11, 12, "R10 R9 start and end same cycle");
    step(1, 1, 0, 0, 0, 13, 14, "R10 empty single-beat road");
    idle("R2 R11 idle");

    // random roads
    for (int r = 0; r < 60; r++) begin
      int n;
      n = int'($urandom_range(0, 8));
      step(1, n == 0, 1, int'($urandom_range(0, 3)), int'($urandom_range(0, 3000)) - 1500,
           int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)), "R3 R6 R8 random");
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 3) == 0) idle("R2 random gap");
        step(0, k == n - 1, $urandom_range(0, 4) != 0, int'($urandom_range(0, 3)),
             int'($urandom_range(0, 2400)) - 1200, 0, 0, "R3 R4 R5 random");
      end
      if ($urandom_range(0, 1) == 0) idle("R11 random hold");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule